// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit load/store instruction into the control word that steers a single-cycle datapath. It is purely combinational: the fields arrive from instruction memory and the control word is valid after the decode delay, within the same cycle. A main decoder reads only the opcode and drives the ten datapath controls: destination register choice, register write enable, immediate extension kind, second ALU operand source, memory read, memory write, write-back source, the two branch flags and the jump flag. A separate ALU-control stage reads both fields and produces a 4-bit ALU operation code.

The supported set is add, sub, and, or, xor and slt as register-register forms under opcode zero. The immediate forms are addi, slti, andi, ori and xori. The other instructions are lw, sw, beq, bne and j. An opcode outside this set, or a function code outside this list under opcode zero, produces a control word that writes nothing and redirects nothing, so the datapath just steps past the instruction.

Top module: `insn_ctl_dec`

## Requirements
- R1: `dst_rd_o` is 1 exactly when the opcode is 0x00, and 0 for every other opcode.
- R2: `reg_we_o` is 1 for a known register-register instruction and for addi (0x08), slti (0x0A), andi (0x0C), ori (0x0D), xori (0x0E) and lw (0x23). It is 0 for sw (0x2B), beq (0x04), bne (0x05) and j (0x02).
- R3: `imm_sign_o` is 0 (zero-extend) for andi, ori and xori, and 1 (sign-extend) for every other opcode.
- R4: `opb_imm_o` is 0 (operand from the second register) for opcode 0x00, beq and bne, and 1 (extended immediate) for every other opcode.
- R5: `mem_rd_o` and `wb_mem_o` are 1 only for lw. `mem_we_o` is 1 only for sw.
- R6: `br_eq_o` is 1 only for beq, `br_ne_o` only for bne and `jump_o` only for j. For j no register or memory write or memory read is requested.
- R7: Under opcode 0x00 the ALU code follows the function field. The code is {unit[1:0], sub[1:0]}, with unit values shift 00, slt 01, arithmetic 10 and logic 11. This gives add (0x20) 4'b1000, sub (0x22) 4'b1001, and (0x24) 4'b1100, or (0x25) 4'b1101, xor (0x26) 4'b1111 and slt (0x2A) 4'b0100.
- R8: For other opcodes the ALU code follows the opcode. addi, lw and sw give 4'b1000 (add). slti gives 4'b0100. andi gives 4'b1100, ori 4'b1101 and xori 4'b1111. beq and bne give 4'b1001 (subtract). j gives 4'b0000.
- R9: For an opcode outside the supported set, `reg_we_o`, `mem_rd_o`, `mem_we_o`, `wb_mem_o`, `br_eq_o`, `br_ne_o`, `jump_o` and `dst_rd_o` are 0, the ALU code is 4'b0000, and `imm_sign_o` and `opb_imm_o` are 1.
- R10: Under opcode 0x00 with an unsupported function code, `reg_we_o` and all memory, branch and jump outputs are 0 and the ALU code is 4'b0000. `dst_rd_o` stays 1, `opb_imm_o` 0 and `imm_sign_o` 1.
- R11: For any opcode other than 0x00, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode field of the instruction |
| fn_i | input | 6 | Function field of the instruction |
| dst_rd_o | output | 1 | 1 selects the Rd field as write register, 0 selects Rt |
| reg_we_o | output | 1 | Register file write enable |
| imm_sign_o | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| opb_imm_o | output | 1 | 1 feeds the extended immediate to the second ALU operand |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_we_o | output | 1 | Data memory write enable |
| wb_mem_o | output | 1 | 1 writes memory data back instead of the ALU result |
| br_eq_o | output | 1 | Branch-if-equal request |
| br_ne_o | output | 1 | Branch-if-not-equal request |
| jump_o | output | 1 | Unconditional jump request |
| alu_op_o | output | 4 | ALU operation code {unit, sub-op} |

## Verification
The hardest situation to reach is a register-register opcode that carries a function code the ALU stage does not know. In that case the main decoder still sees a valid class, and only the function-field check stops the register write. The stimulus drives opcode 0x00 across every one of the 64 function values, so the six known codes and all 58 unknown ones are each compared with a model. The same function sweep is then repeated under immediate, memory and branch opcodes to show that the field is ignored there. Every one of the 64 opcodes is also checked, so each unassigned code is proved harmless.

// File: rtl/insn_ctl_pkg.sv
package insn_ctl_pkg;

  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int SUB_W = 2;
  localparam int ALU_W = 2 + SUB_W;

  localparam logic [OP_W-1:0] OP_REG  = 6'h00;
  localparam logic [OP_W-1:0] OP_JMP  = 6'h02;
  localparam logic [OP_W-1:0] OP_BEQ  = 6'h04;
  localparam logic [OP_W-1:0] OP_BNE  = 6'h05;
  localparam logic [OP_W-1:0] OP_ADDI = 6'h08;
  localparam logic [OP_W-1:0] OP_SLTI = 6'h0A;
  localparam logic [OP_W-1:0] OP_ANDI = 6'h0C;
  localparam logic [OP_W-1:0] OP_ORI  = 6'h0D;
  localparam logic [OP_W-1:0] OP_XORI = 6'h0E;
  localparam logic [OP_W-1:0] OP_LW   = 6'h23;
  localparam logic [OP_W-1:0] OP_SW   = 6'h2B;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR = 6'h26;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    UNIT_SHIFT = 2'b00,
    UNIT_SLT   = 2'b01,
    UNIT_ARITH = 2'b10,
    UNIT_LOGIC = 2'b11
  } unit_e;

  localparam logic [SUB_W-1:0] SUB_ADD = 2'b00;
  localparam logic [SUB_W-1:0] SUB_SUB = 2'b01;
  localparam logic [SUB_W-1:0] SUB_AND = 2'b00;
  localparam logic [SUB_W-1:0] SUB_OR  = 2'b01;
  localparam logic [SUB_W-1:0] SUB_XOR = 2'b11;

  // One flag per supported instruction class
  typedef struct packed {
    logic reg_rr;
    logic jmp;
    logic beq;
    logic bne;
    logic addi;
    logic slti;
    logic andi;
    logic ori;
    logic xori;
    logic lw;
    logic sw;
  } insn_hot_t;

  typedef struct packed {
    logic dst_rd;
    logic reg_we;
    logic imm_sign;
    logic opb_imm;
    logic mem_rd;
    logic mem_we;
    logic wb_mem;
    logic br_eq;
    logic br_ne;
    logic jump;
  } ctl_word_t;

  function automatic logic [ALU_W-1:0] alu_code(unit_e unit, logic [SUB_W-1:0] sub);
    return {unit, sub};
  endfunction

endpackage

// File: rtl/insn_op_decode.sv
module insn_op_decode
  import insn_ctl_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] op_i,
  output insn_hot_t      hot_o,
  output logic           known_o
);

  function automatic logic hit(logic [OPW-1:0] op, logic [OP_W-1:0] code);
    return op == OPW'(code);
  endfunction

  always_comb begin
    hot_o.reg_rr = hit(op_i, OP_REG);
    hot_o.jmp    = hit(op_i, OP_JMP);
    hot_o.beq    = hit(op_i, OP_BEQ);
    hot_o.bne    = hit(op_i, OP_BNE);
    hot_o.addi   = hit(op_i, OP_ADDI);
    hot_o.slti   = hit(op_i, OP_SLTI);
    hot_o.andi   = hit(op_i, OP_ANDI);
    hot_o.ori    = hit(op_i, OP_ORI);
    hot_o.xori   = hit(op_i, OP_XORI);
    hot_o.lw     = hit(op_i, OP_LW);
    hot_o.sw     = hit(op_i, OP_SW);
  end

  assign known_o = |hot_o;

endmodule

// File: rtl/insn_alu_ctl.sv
module insn_alu_ctl
  import insn_ctl_pkg::*;
#(
  parameter int FNW = FN_W,
  parameter int AW  = ALU_W
) (
  input  insn_hot_t      hot_i,
  input  logic [FNW-1:0] fn_i,
  output logic [AW-1:0]  alu_op_o,
  output logic           fn_ok_o
);

  logic [AW-1:0] fn_code;
  logic [AW-1:0] op_code;

  // Register-register class: operation taken from the function field
  always_comb begin
    fn_code = '0;
    fn_ok_o = 1'b0;
    case (fn_i)
      FNW'(FN_ADD): begin fn_code = AW'(alu_code(UNIT_ARITH, SUB_ADD)); fn_ok_o = 1'b1; end
      FNW'(FN_SUB): begin fn_code = AW'(alu_code(UNIT_ARITH, SUB_SUB)); fn_ok_o = 1'b1; end
      FNW'(FN_AND): begin fn_code = AW'(alu_code(UNIT_LOGIC, SUB_AND)); fn_ok_o = 1'b1; end
      FNW'(FN_OR):  begin fn_code = AW'(alu_code(UNIT_LOGIC, SUB_OR));  fn_ok_o = 1'b1; end
      FNW'(FN_XOR): begin fn_code = AW'(alu_code(UNIT_LOGIC, SUB_XOR)); fn_ok_o = 1'b1; end
      FNW'(FN_SLT): begin fn_code = AW'(alu_code(UNIT_SLT, SUB_ADD));   fn_ok_o = 1'b1; end
      default: ;
    endcase
  end

  // Every other class: operation taken from the opcode
  always_comb begin
    op_code = '0;
    if (hot_i.addi | hot_i.lw | hot_i.sw)
      op_code = AW'(alu_code(UNIT_ARITH, SUB_ADD));
    else if (hot_i.beq | hot_i.bne)
      op_code = AW'(alu_code(UNIT_ARITH, SUB_SUB));
    else if (hot_i.slti)
      op_code = AW'(alu_code(UNIT_SLT, SUB_ADD));
    else if (hot_i.andi)
      op_code = AW'(alu_code(UNIT_LOGIC, SUB_AND));
    else if (hot_i.ori)
      op_code = AW'(alu_code(UNIT_LOGIC, SUB_OR));
    else if (hot_i.xori)
      op_code = AW'(alu_code(UNIT_LOGIC, SUB_XOR));
    else if (hot_i.jmp)
      op_code = AW'(alu_code(UNIT_SHIFT, SUB_ADD));
  end

  assign alu_op_o = hot_i.reg_rr ? (fn_ok_o ? fn_code : '0) : op_code;

endmodule

// File: rtl/insn_main_ctl.sv
module insn_main_ctl
  import insn_ctl_pkg::*;
(
  input  insn_hot_t hot_i,
  input  logic      fn_ok_i,
  output ctl_word_t ctl_o
);

  logic zero_ext;
  logic opb_reg;
  logic writes_reg;

  assign zero_ext   = hot_i.andi | hot_i.ori | hot_i.xori;
  assign opb_reg    = hot_i.reg_rr | hot_i.beq | hot_i.bne;
  assign writes_reg = (hot_i.reg_rr & fn_ok_i) | hot_i.addi | hot_i.slti |
                      hot_i.andi | hot_i.ori | hot_i.xori | hot_i.lw;

  always_comb begin
    ctl_o.dst_rd   = hot_i.reg_rr;
    ctl_o.reg_we   = writes_reg;
    ctl_o.imm_sign = ~zero_ext;
    ctl_o.opb_imm  = ~opb_reg;
    ctl_o.mem_rd   = hot_i.lw;
    ctl_o.mem_we   = hot_i.sw;
    ctl_o.wb_mem   = hot_i.lw;
    ctl_o.br_eq    = hot_i.beq;
    ctl_o.br_ne    = hot_i.bne;
    ctl_o.jump     = hot_i.jmp;
  end

endmodule

// File: rtl/insn_ctl_dec.sv
module insn_ctl_dec
  import insn_ctl_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output logic       dst_rd_o,
  output logic       reg_we_o,
  output logic       imm_sign_o,
  output logic       opb_imm_o,
  output logic       mem_rd_o,
  output logic       mem_we_o,
  output logic       wb_mem_o,
  output logic       br_eq_o,
  output logic       br_ne_o,
  output logic       jump_o,
  output logic [3:0] alu_op_o
);

  insn_hot_t hot;
  ctl_word_t ctl;
  logic      insn_known;
  logic      fn_known;

  insn_op_decode #(.OPW(OP_W)) u_dec (
    .op_i    (op_i),
    .hot_o   (hot),
    .known_o (insn_known)
  );

  insn_alu_ctl #(.FNW(FN_W), .AW(ALU_W)) u_alu (
    .hot_i    (hot),
    .fn_i     (fn_i),
    .alu_op_o (alu_op_o),
    .fn_ok_o  (fn_known)
  );

  insn_main_ctl u_main (
    .hot_i   (hot),
    .fn_ok_i (fn_known),
    .ctl_o   (ctl)
  );

  assign dst_rd_o   = ctl.dst_rd;
  assign reg_we_o   = ctl.reg_we;
  assign imm_sign_o = ctl.imm_sign;
  assign opb_imm_o  = ctl.opb_imm;
  assign mem_rd_o   = ctl.mem_rd;
  assign mem_we_o   = ctl.mem_we;
  assign wb_mem_o   = ctl.wb_mem;
  assign br_eq_o    = ctl.br_eq;
  assign br_ne_o    = ctl.br_ne;
  assign jump_o     = ctl.jump;

endmodule

// File: rtl/insn_ctl_chk.sv
module insn_ctl_chk (
  input logic [5:0] op,
  input logic       known,
  input logic       fn_ok,
  input logic       dst_rd,
  input logic       reg_we,
  input logic       opb_imm,
  input logic       mem_rd,
  input logic       mem_we,
  input logic       wb_mem,
  input logic       br_eq,
  input logic       br_ne,
  input logic       jump,
  input logic [3:0] alu_op
);

  always_comb begin
    // R5: a load reads memory and writes that data back, together
    p_load_pair_r5: assert (mem_rd == wb_mem)
      else $error("p_load_pair_r5");
    // R5: a store never also writes a register or reads memory
    if (mem_we)
      p_store_quiet_r5: assert (!reg_we && !mem_rd)
        else $error("p_store_quiet_r5");
    // R6: at most one redirect flag at once
    p_redirect_one_r6: assert ($onehot0({br_eq, br_ne, jump}))
      else $error("p_redirect_one_r6");
    // R6: a jump requests no write and no read
    if (jump)
      p_jump_quiet_r6: assert (!reg_we && !mem_we && !mem_rd)
        else $error("p_jump_quiet_r6");
    // R8: branches compare by subtracting two registers
    if (br_eq || br_ne)
      p_branch_sub_r8: assert (alu_op == 4'b1001 && !opb_imm)
        else $error("p_branch_sub_r8");
    // R9: unknown opcode is harmless
    if (!known)
      p_unknown_op_r9: assert (!reg_we && !mem_rd && !mem_we && !br_eq && !br_ne && !jump && alu_op == 4'b0000)
        else $error("p_unknown_op_r9");
    // R10: register class with unknown function code writes nothing
    if (dst_rd && !fn_ok)
      p_unknown_fn_r10: assert (!reg_we && alu_op == 4'b0000)
        else $error("p_unknown_fn_r10");
    // R1: register destination only under opcode zero
    p_rd_select_r1: assert (dst_rd == (op == 6'h00))
      else $error("p_rd_select_r1");
  end

endmodule

bind insn_ctl_dec insn_ctl_chk u_chk (
  .op      (op_i),
  .known   (insn_known),
  .fn_ok   (fn_known),
  .dst_rd  (dst_rd_o),
  .reg_we  (reg_we_o),
  .opb_imm (opb_imm_o),
  .mem_rd  (mem_rd_o),
  .mem_we  (mem_we_o),
  .wb_mem  (wb_mem_o),
  .br_eq   (br_eq_o),
  .br_ne   (br_ne_o),
  .jump    (jump_o),
  .alu_op  (alu_op_o)
);

// File: tb/sim_insn_ctl_dec.sv
`timescale 1ns/1ps
module sim_insn_ctl_dec;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [5:0] op, fn;
  logic dst_rd, reg_we, imm_sign, opb_imm, mem_rd, mem_we, wb_mem, br_eq, br_ne, jump;
  logic [3:0] alu_op;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  insn_ctl_dec u0 (
    .op_i(op), .fn_i(fn),
    .dst_rd_o(dst_rd), .reg_we_o(reg_we), .imm_sign_o(imm_sign), .opb_imm_o(opb_imm),
    .mem_rd_o(mem_rd), .mem_we_o(mem_we), .wb_mem_o(wb_mem),
    .br_eq_o(br_eq), .br_ne_o(br_ne), .jump_o(jump), .alu_op_o(alu_op)
  );

  // Packed view: {dst_rd, reg_we, imm_sign, opb_imm, mem_rd, mem_we, wb_mem, br_eq, br_ne, jump, alu[3:0]}
  function automatic logic [13:0] model(logic [5:0] o, logic [5:0] f);
    logic [13:0] e;
    e = {1'b0, 1'b0, 1'b1, 1'b1, 6'b0, 4'b0000};
    case (o)
      6'h00: begin
        e[13] = 1'b1; e[10] = 1'b0;
        case (f)
          6'h20: begin e[12] = 1'b1; e[3:0] = 4'b1000; end
          6'h22: begin e[12] = 1'b1; e[3:0] = 4'b1001; end
          6'h24: begin e[12] = 1'b1; e[3:0] = 4'b1100; end
          6'h25: begin e[12] = 1'b1; e[3:0] = 4'b1101; end
          6'h26: begin e[12] = 1'b1; e[3:0] = 4'b1111; end
          6'h2A: begin e[12] = 1'b1; e[3:0] = 4'b0100; end
          default: ;
        endcase
      end
      6'h02: e[4] = 1'b1;
      6'h04: begin e[10] = 1'b0; e[6] = 1'b1; e[3:0] = 4'b1001; end
      6'h05: begin e[10] = 1'b0; e[5] = 1'b1; e[3:0] = 4'b1001; end
      6'h08: begin e[12] = 1'b1; e[3:0] = 4'b1000; end
      6'h0A: begin e[12] = 1'b1; e[3:0] = 4'b0100; end
      6'h0C: begin e[12] = 1'b1; e[11] = 1'b0; e[3:0] = 4'b1100; end
      6'h0D: begin e[12] = 1'b1; e[11] = 1'b0; e[3:0] = 4'b1101; end
      6'h0E: begin e[12] = 1'b1; e[11] = 1'b0; e[3:0] = 4'b1111; end
      6'h23: begin e[12] = 1'b1; e[9] = 1'b1; e[7] = 1'b1; e[3:0] = 4'b1000; end
      6'h2B: begin e[8] = 1'b1; e[3:0] = 4'b1000; end
      default: ;
    endcase
    return e;
  endfunction

  function automatic bit is_known(logic [5:0] o);
    return o inside {6'h00, 6'h02, 6'h04, 6'h05, 6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h23, 6'h2B};
  endfunction

  function automatic logic [13:0] outs();
    return {dst_rd, reg_we, imm_sign, opb_imm, mem_rd, mem_we, wb_mem, br_eq, br_ne, jump, alu_op};
  endfunction

  task automatic apply(input logic [5:0] o, input logic [5:0] f);
    @(posedge clk);
    op = o; fn = f;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [13:0] got, input logic [13:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%h fn=%h actual=%b expected=%b", tag, op, fn, got, exp);
    end
  endtask

  task automatic t_idle();
    apply(6'h3F, 6'h00);
    check("R9 idle word", outs(), {4'b0011, 6'b0, 4'b0000});
  endtask

  task automatic t_reg_class();
    logic [5:0] fns [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A};
    foreach (fns[i]) begin
      apply(6'h00, fns[i]);
      check("R7 R1 R2 reg-reg", outs(), model(6'h00, fns[i]));
    end
  endtask

  task automatic t_imm_class();
    logic [5:0] ops [5] = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E};
    foreach (ops[i]) begin
      apply(ops[i], 6'h11);
      check("R8 R3 R4 R2 immediate", outs(), model(ops[i], 6'h11));
    end
  endtask

  task automatic t_memory();
    apply(6'h23, 6'h00);
    check("R5 lw", outs(), model(6'h23, 6'h00));
    check("R5 lw read bits", {mem_rd, wb_mem, mem_we}, 14'b110);
    apply(6'h2B, 6'h00);
    check("R5 sw", outs(), model(6'h2B, 6'h00));
    check("R2 sw no reg write", {13'b0, reg_we}, 14'b0);
  endtask

  task automatic t_redirect();
    apply(6'h04, 6'h2A);
    check("R6 beq", outs(), model(6'h04, 6'h2A));
    apply(6'h05, 6'h2A);
    check("R6 bne", outs(), model(6'h05, 6'h2A));
    apply(6'h02, 6'h20);
    check("R6 j", outs(), model(6'h02, 6'h20));
    check("R6 j only jump", {11'b0, br_eq, br_ne, jump}, 14'b001);
  endtask

  task automatic t_all_opcodes();
    for (int o = 0; o < 64; o++) begin
      apply(6'(o), 6'h20);
      if (is_known(6'(o)))
        check("R1 known opcode", outs(), model(6'(o), 6'h20));
      else
        check("R9 unknown opcode", outs(), {4'b0011, 6'b0, 4'b0000});
    end
  endtask

  task automatic t_all_functs();
    for (int f = 0; f < 64; f++) begin
      apply(6'h00, 6'(f));
      check("R10 R7 function sweep", outs(), model(6'h00, 6'(f)));
    end
    apply(6'h00, 6'h21);
    check("R10 unknown funct", outs(), {4'b1010, 6'b0, 4'b0000});
  endtask

  task automatic t_fn_ignored();
    logic [5:0] ops [4] = '{6'h0C, 6'h23, 6'h05, 6'h01};
    foreach (ops[i]) begin
      logic [13:0] ref_w;
      apply(ops[i], 6'h00);
      ref_w = outs();
      check("R11 baseline", ref_w, model(ops[i], 6'h00));
      for (int f = 1; f < 64; f++) begin
        apply(ops[i], 6'(f));
        check("R11 funct ignored", outs(), ref_w);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op = 6'h3F; fn = 6'h00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_reg_class();
    t_imm_class();
    t_memory();
    t_redirect();
    t_all_opcodes();
    t_all_functs();
    t_fn_ignored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule